// File: doc/BRIEF.md
# Pipelined Unit Issue Scoreboard

This block tracks the operations in flight inside one pipelined functional unit of depth N. It tells the issue stage whether a candidate operation may enter the unit this cycle. The unit is treated as N virtual single-operation slots. A one-hot pointer hands them out in rotation. Each slot holds the destination register of its operation and a countdown of the cycles left until that operation's result is written back.

For each candidate, the issue stage presents:
- an issue request,
- a destination register,
- two source registers,
- the latency the candidate would take to produce its result.

The block then raises three hazard flags:
- a read-after-write flag, when a source matches a pending destination;
- a same-destination flag, when the destination matches a pending one;
- a writeback-collision flag, when the candidate would finish in the same cycle as an operation already in flight.

The candidate is taken into a slot only when no flag is raised and the pipeline is neither stalled nor flushed. A stall freezes all tracking. A flush empties every slot and returns the pointer to the first slot.

Top module: `pipe_unit_scoreboard`

## Requirements
- R1: After reset every bit of `slotBusy` is 0, and all three hazard flags are 0 whatever values the request inputs hold.
- R2: The slot pointer starts at slot 0 (bit 0 of `slotBusy`). It moves up by one slot on each accepted issue and wraps from slot N-1 back to slot 0, so consecutive accepted issues occupy slots 0, 1, ..., N-1, 0 in turn.
- R3: An accepted issue loads the selected slot's countdown with N and records its destination register. The countdown then drops by one on every cycle without stall or flush until it reaches 0. A slot's `slotBusy` bit is 1 while its countdown is greater than 1, so it is 1 for N-1 unstalled cycles after the accepting edge.
- R4: `rawHazard` is 1 when `srcRegA` or `srcRegB` equals the destination of a busy slot.
- R5: Register 0 never causes a hazard: a busy slot whose destination is 0 raises neither `rawHazard` nor `wawHazard`.
- R6: `wawHazard` is 1 when `destReg` equals the nonzero destination of a busy slot.
- R7: `latHazard` is 1 when `reqLatency` equals the remaining countdown of a busy slot.
- R8: An issue is accepted only when `issueReq` is 1, `stall` is 0, `flush` is 0 and all three hazard flags are 0. A request that is not accepted leaves the pointer and all slots unchanged.
- R9: While `stall` is 1 and `flush` is 0, neither the countdowns nor the pointer change, and no issue is accepted.
- R10: `flush` clears every countdown to 0 and returns the pointer to slot 0 at the next edge, regardless of `stall` and `issueReq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| issueReq | input | 1 | A candidate operation asks to enter the unit |
| destReg | input | RegW | Destination register of the candidate |
| srcRegA | input | RegW | First source register of the candidate |
| srcRegB | input | RegW | Second source register of the candidate |
| reqLatency | input | CntW | Cycles the candidate needs until writeback |
| stall | input | 1 | Freeze all tracking this cycle |
| flush | input | 1 | Drop all tracked operations |
| rawHazard | output | 1 | A source depends on a pending result |
| wawHazard | output | 1 | The destination is already pending |
| latHazard | output | 1 | The candidate's writeback cycle is taken |
| slotBusy | output | NumSlots | Per-slot executing status |

## Verification
A stream of issues with distinct destinations is used to show rotation and wrap of the slots. Directed requests then repeat a pending destination, read it as a source, name register 0, or ask for the latency equal to a slot's remaining count; these separate the three hazard kinds from one another and from the register-0 exemption. Stall runs and flushes placed in the middle of activity show the difference between freezing the slots and clearing them. A long pseudo-random mix of all of these is compared on every cycle against a behavioural model of the slots. That mix reaches combinations such as a hazard raised at the same time as a stall or a flush.

// File: rtl/sb_pkg.sv
package sb_pkg;
  // Strobes from issue control to the slot datapath
  typedef struct packed {
    logic load;   // accepted issue enters the selected slot
    logic clear;  // flush: empty every slot
    logic hold;   // stall: freeze every slot
  } sbStrobe_t;
endpackage

// File: rtl/sb_issue_ctrl.sv
module sb_issue_ctrl
  import sb_pkg::*;
#(
  parameter int NumSlots = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                issueReq,
  input  logic                stall,
  input  logic                flush,
  input  logic                anyHazard,
  output sbStrobe_t           strobe,
  output logic [NumSlots-1:0] slotSel
);
  localparam logic [NumSlots-1:0] FirstSlot = NumSlots'(1);

  always_comb begin
    strobe.clear = flush;
    strobe.hold  = stall & ~flush;
    strobe.load  = issueReq & ~stall & ~flush & ~anyHazard;
  end

  // one-hot rotating slot pointer
  always_ff @(posedge clk) begin
    if (!rstN) begin
      slotSel <= FirstSlot;
    end else if (strobe.clear) begin
      slotSel <= FirstSlot;
    end else if (strobe.load) begin
      if (slotSel[NumSlots-1]) slotSel <= FirstSlot;
      else                     slotSel <= slotSel << 1;
    end
  end

  p_sel_onehot_r2: assert property (@(posedge clk) disable iff (!rstN)
    $countones(slotSel) == 1);
  p_sel_frozen_r9: assert property (@(posedge clk) disable iff (!rstN)
    (stall && !flush) |=> $stable(slotSel));
  p_flush_sel_r10: assert property (@(posedge clk) disable iff (!rstN)
    flush |=> (slotSel == FirstSlot));
  p_blocked_r8: assert property (@(posedge clk) disable iff (!rstN)
    anyHazard |-> !strobe.load);
endmodule

// File: rtl/sb_slot_track.sv
module sb_slot_track
  import sb_pkg::*;
#(
  parameter int NumSlots = 4,
  parameter int RegW     = 5,
  parameter int CntW     = $clog2(NumSlots + 1)
) (
  input  logic                clk,
  input  logic                rstN,
  input  sbStrobe_t           strobe,
  input  logic [NumSlots-1:0] slotSel,
  input  logic [RegW-1:0]     destReg,
  input  logic [RegW-1:0]     srcRegA,
  input  logic [RegW-1:0]     srcRegB,
  input  logic [CntW-1:0]     reqLatency,
  output logic                rawHazard,
  output logic                wawHazard,
  output logic                latHazard,
  output logic                anyHazard,
  output logic [NumSlots-1:0] slotBusy
);
  localparam logic [CntW-1:0] FullCount = CntW'(NumSlots);
  localparam logic [RegW-1:0] ZeroReg   = '0;

  logic [NumSlots-1:0][CntW-1:0] remain;
  logic [NumSlots-1:0][RegW-1:0] slotDest;
  logic [NumSlots-1:0]           rawVec, wawVec, latVec;

  for (genvar i = 0; i < NumSlots; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rstN) begin
        remain[i] <= '0;
      end else if (strobe.clear) begin
        remain[i] <= '0;
      end else if (!strobe.hold) begin
        if (strobe.load && slotSel[i]) remain[i] <= FullCount;
        else if (remain[i] != '0)      remain[i] <= remain[i] - CntW'(1);
      end
    end

    always_ff @(posedge clk) begin
      if (!rstN)                          slotDest[i] <= '0;
      else if (strobe.load && slotSel[i]) slotDest[i] <= destReg;
    end

    assign slotBusy[i] = (remain[i] > CntW'(1));
    assign rawVec[i]   = slotBusy[i] && (slotDest[i] != ZeroReg) &&
                         ((srcRegA == slotDest[i]) || (srcRegB == slotDest[i]));
    assign wawVec[i]   = slotBusy[i] && (slotDest[i] != ZeroReg) &&
                         (destReg == slotDest[i]);
    assign latVec[i]   = slotBusy[i] && (reqLatency == remain[i]);

    p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rstN)
      remain[i] <= FullCount);
  end

  assign rawHazard = |rawVec;
  assign wawHazard = |wawVec;
  assign latHazard = |latVec;
  assign anyHazard = rawHazard | wawHazard | latHazard;

  p_load_busy_r3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |=> (slotBusy != '0));
  p_no_growth_r8: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.load |=> ($countones(slotBusy) <= $past($countones(slotBusy))));
  p_flush_idle_r10: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clear |=> (slotBusy == '0));
  p_zero_reg_r5: assert property (@(posedge clk) disable iff (!rstN)
    (srcRegA == ZeroReg && srcRegB == ZeroReg && destReg == ZeroReg)
      |-> (!rawHazard && !wawHazard));
endmodule

// File: rtl/pipe_unit_scoreboard.sv
module pipe_unit_scoreboard
  import sb_pkg::*;
#(
  parameter int NumSlots = 4,
  parameter int RegW     = 5,
  parameter int CntW     = $clog2(NumSlots + 1)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                issueReq,
  input  logic [RegW-1:0]     destReg,
  input  logic [RegW-1:0]     srcRegA,
  input  logic [RegW-1:0]     srcRegB,
  input  logic [CntW-1:0]     reqLatency,
  input  logic                stall,
  input  logic                flush,
  output logic                rawHazard,
  output logic                wawHazard,
  output logic                latHazard,
  output logic [NumSlots-1:0] slotBusy
);
  sbStrobe_t           strobe;
  logic [NumSlots-1:0] slotSel;
  logic                anyHazard;

  sb_issue_ctrl #(.NumSlots(NumSlots)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .issueReq  (issueReq),
    .stall     (stall),
    .flush     (flush),
    .anyHazard (anyHazard),
    .strobe    (strobe),
    .slotSel   (slotSel)
  );

  sb_slot_track #(.NumSlots(NumSlots), .RegW(RegW), .CntW(CntW)) u_track (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .slotSel    (slotSel),
    .destReg    (destReg),
    .srcRegA    (srcRegA),
    .srcRegB    (srcRegB),
    .reqLatency (reqLatency),
    .rawHazard  (rawHazard),
    .wawHazard  (wawHazard),
    .latHazard  (latHazard),
    .anyHazard  (anyHazard),
    .slotBusy   (slotBusy)
  );
endmodule

// File: tb/pipe_unit_scoreboard_tb_top.sv
`timescale 1ns/1ps
module pipe_unit_scoreboard_tb_top;
  localparam int N  = 4;
  localparam int RW = 5;
  localparam int CW = $clog2(N + 1);

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          issueReq = 1'b0;
  logic [RW-1:0] destReg = '0, srcRegA = '0, srcRegB = '0;
  logic [CW-1:0] reqLatency = '0;
  logic          stall = 1'b0, flush = 1'b0;
  logic          rawHazard, wawHazard, latHazard;
  logic [N-1:0]  slotBusy;

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  // behavioural model state
  int mRemain[N];
  int mDest[N];
  int mPtr;

  always #2.5 clk = ~clk;

  pipe_unit_scoreboard #(.NumSlots(N), .RegW(RW), .CntW(CW)) dut_i (
    .clk(clk), .rstN(rstN), .issueReq(issueReq), .destReg(destReg),
    .srcRegA(srcRegA), .srcRegB(srcRegB), .reqLatency(reqLatency),
    .stall(stall), .flush(flush), .rawHazard(rawHazard),
    .wawHazard(wawHazard), .latHazard(latHazard), .slotBusy(slotBusy)
  );

  function automatic bit mBusy(int s);
    return mRemain[s] > 1;
  endfunction

  function automatic bit mRaw();
    for (int s = 0; s < N; s++)
      if (mBusy(s) && mDest[s] != 0 &&
          (mDest[s] == int'(srcRegA) || mDest[s] == int'(srcRegB))) return 1;
    return 0;
  endfunction

  function automatic bit mWaw();
    for (int s = 0; s < N; s++)
      if (mBusy(s) && mDest[s] != 0 && mDest[s] == int'(destReg)) return 1;
    return 0;
  endfunction

  function automatic bit mLat();
    for (int s = 0; s < N; s++)
      if (mBusy(s) && mRemain[s] == int'(reqLatency)) return 1;
    return 0;
  endfunction

  function automatic logic [N-1:0] mBusyVec();
    logic [N-1:0] v = '0;
    for (int s = 0; s < N; s++) v[s] = mBusy(s);
    return v;
  endfunction

  // model update at each rising edge
  always @(posedge clk) begin
    if (!rstN) begin
      for (int s = 0; s < N; s++) begin mRemain[s] = 0; mDest[s] = 0; end
      mPtr = 0;
    end else if (flush) begin
      for (int s = 0; s < N; s++) mRemain[s] = 0;
      mPtr = 0;
    end else if (!stall) begin
      bit take;
      take = issueReq && !mRaw() && !mWaw() && !mLat();
      for (int s = 0; s < N; s++) begin
        if (take && s == mPtr) begin
          mRemain[s] = N; mDest[s] = int'(destReg);
        end else if (mRemain[s] > 0) begin
          mRemain[s] = mRemain[s] - 1;
        end
      end
      if (take) mPtr = (mPtr + 1) % N;
    end
  end

  task automatic checkOne(string tag, string what, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic compareAll(string tag);
    checkOne({tag, "/R3"}, "slotBusy", int'(slotBusy), int'(mBusyVec()));
    checkOne({tag, "/R4"}, "rawHazard", int'(rawHazard), int'(mRaw()));
    checkOne({tag, "/R6"}, "wawHazard", int'(wawHazard), int'(mWaw()));
    checkOne({tag, "/R7"}, "latHazard", int'(latHazard), int'(mLat()));
  endtask

  task automatic step(string tag, bit iss, int d, int a, int b, int lat, bit st, bit fl);
    @(negedge clk);
    issueReq = iss; destReg = RW'(d); srcRegA = RW'(a); srcRegB = RW'(b);
    reqLatency = CW'(lat); stall = st; flush = fl;
    #1;
    compareAll(tag);
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      mismatched++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1: idle after reset, any request inputs
    step("R1", 0, 7, 7, 7, 2, 0, 0);
    checkOne("R1", "slotBusy", int'(slotBusy), 0);
    step("R1", 1, 0, 0, 0, 0, 0, 0);    // also R5: x0 issue is accepted
    // R2: rotation across slots with distinct destinations
    step("R2", 1, 1, 0, 0, 1, 0, 0);
    checkOne("R2", "slotBusy", int'(slotBusy), 'b0001);
    step("R2", 1, 2, 0, 0, 1, 0, 0);
    checkOne("R2", "slotBusy", int'(slotBusy), 'b0011);
    // R4: read of pending register 2; R8: blocked leaves slots
    step("R4", 1, 9, 2, 0, 1, 0, 0);
    checkOne("R4", "rawHazard", int'(rawHazard), 1);
    step("R8", 0, 0, 0, 0, 1, 0, 0);
    // R5: slot with destination 0 raises no hazard for x0 operands
    step("R5", 0, 0, 0, 0, 1, 0, 0);
    checkOne("R5", "rawHazard", int'(rawHazard), 0);
    // flush, then reload and probe WAW and latency
    step("R10", 1, 4, 0, 0, 1, 1, 1);
    step("R10", 0, 0, 0, 0, 1, 0, 0);
    checkOne("R10", "slotBusy", int'(slotBusy), 0);
    step("R10", 1, 3, 0, 0, 1, 0, 0);
    step("R6", 1, 3, 0, 0, 1, 0, 0);
    checkOne("R6", "wawHazard", int'(wawHazard), 1);
    checkOne("R10", "slotBusy", int'(slotBusy), 'b0001);
    step("R7", 1, 8, 0, 0, 3, 0, 0);
    checkOne("R7", "latHazard", int'(latHazard), 1);
    // R9: stall freezes
    step("R9", 1, 10, 0, 0, 1, 1, 0);
    step("R9", 1, 11, 0, 0, 1, 1, 0);
    checkOne("R9", "slotBusy", int'(slotBusy), 'b0001);
    // R2 wrap: keep issuing distinct destinations
    for (int k = 0; k < 12; k++) step("R2", 1, 12 + k, 0, 0, 1, 0, 0);
    // pseudo-random mix
    for (int k = 0; k < 3000; k++)
      step("MIX", ($urandom_range(0, 7) != 0), $urandom_range(0, 7),
           $urandom_range(0, 7), $urandom_range(0, 7), $urandom_range(0, N),
           ($urandom_range(0, 7) == 0), ($urandom_range(0, 31) == 0));
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule